// File: doc/BRIEF.md
# Dual-Processor Watchdog Failover Controller

This block watches over a pair of processors, where one is in charge and the other waits as a spare. A watchdog timer runs while the processor in charge is active. That processor must show that it is alive by sending a kick strobe, tagged with its own identifier, before a programmable number of cycles has elapsed. If no such kick arrives in time, the controller hands control to the other processor. It does this by flipping a select output, which steers the shared buses outside this block. At the same moment it lights a CPU fault indicator and emits a one-cycle failover pulse.

The timer reloads to its full interval on every handover, so the new master always gets a complete window to respond. The first valid kick from the new master turns the fault indicator off again. If both processors fail in turn, control returns to the first processor and a sticky double-fault flag is raised. That flag stays set until reset.

Processor 0 is the primary and is in charge after reset. Processor 1 is the spare.

Top module: `cpu_failover_wd`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, activeSel is 0 (processor 0 in charge), faultLed is 0, doubleFault is 0 and failoverPulse is 0, and the timer counts from zero.
- R2: A kick counts only when kickValid is 1 and kickId equals activeSel (0 means processor 0, 1 means processor 1). Each counted kick restarts the timer. With a timeout value T and no counted kick after a restart at clock edge k, the failover outputs change after edge k+T+1.
- R3: A kick whose kickId differs from activeSel is ignored. It neither delays the expiry nor clears the fault indicator.
- R4: On expiry, activeSel toggles, faultLed becomes 1, and failoverPulse is 1 for exactly the one cycle after the switching edge.
- R5: A handover reloads the full timeout, so that with no kicks the next handover follows T+1 cycles after the previous one.
- R6: The first counted kick after a handover clears faultLed, which reads 0 in the cycle after the kick is sampled.
- R7: An expiry while processor 1 is in charge returns control to processor 0, keeps faultLed at 1, and sets doubleFault, which then stays 1 until reset.
- R8: A counted kick sampled in the same cycle in which the timer reaches T prevents the handover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kickValid | input | 1 | Kick strobe |
| kickId | input | 1 | Identifier of the processor sending the kick |
| timeoutCycles | input | CNT_W | Watchdog timeout value T |
| activeSel | output | 1 | Processor in charge; steers the shared buses |
| faultLed | output | 1 | CPU fault indicator |
| doubleFault | output | 1 | Sticky flag: both processors have timed out |
| failoverPulse | output | 1 | One-cycle pulse on each handover |

## Verification
A timer that is off by one, or that is restarted by the wrong processor, shows up at the ports as a failover pulse one cycle early or late. An expiry that should have been rescued shows up as a select flip, again in the cycle after the expiry edge. The bench pins every expected handover to an exact cycle. It also checks the cycle just before each handover, so any drift in the count is caught within a single interval. Wrong fault or double-fault state is visible right after the next kick or the next expiry, because both flags are registered outputs.

// File: rtl/wdfo_pkg.sv
package wdfo_pkg;
  // strobes sent from the control section to the timer datapath
  typedef struct packed {
    logic kickRestart;   // a counted kick from the processor in charge
    logic swapReload;    // a handover, which reloads the full interval
  } wdStrobes_t;
endpackage

// File: rtl/wdfo_timer.sv
module wdfo_timer
  import wdfo_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wdStrobes_t       strobes,
  input  logic [CNT_W-1:0] timeoutCycles,
  output logic             expireNow
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] elapsed;
  logic             restart;

  assign restart   = strobes.kickRestart | strobes.swapReload;
  assign expireNow = (elapsed >= timeoutCycles);

  always_ff @(posedge clk) begin
    if (!rst_n)       elapsed <= '0;
    else if (restart) elapsed <= '0;
    else              elapsed <= elapsed + ONE;
  end

  // R2: any restart strobe brings the count back to zero
  assert_restart_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> elapsed == '0);
  // R2: without a restart the count advances by exactly one
  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> elapsed == $past(elapsed) + ONE);
endmodule

// File: rtl/wdfo_ctrl.sv
module wdfo_ctrl
  import wdfo_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       kickValid,
  input  logic       kickId,
  input  logic       expireNow,
  output wdStrobes_t strobes,
  output logic       activeSel,
  output logic       faultLed,
  output logic       doubleFault,
  output logic       failoverPulse
);
  logic kickOk;
  logic swapNow;

  assign kickOk  = kickValid && (kickId == activeSel);
  assign swapNow = expireNow && !kickOk;

  always_comb begin
    strobes             = '0;
    strobes.kickRestart = kickOk;
    strobes.swapReload  = swapNow;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      activeSel     <= 1'b0;
      faultLed      <= 1'b0;
      doubleFault   <= 1'b0;
      failoverPulse <= 1'b0;
    end else begin
      failoverPulse <= swapNow;
      if (swapNow) begin
        activeSel <= ~activeSel;
        faultLed  <= 1'b1;
        if (activeSel) doubleFault <= 1'b1;
      end else if (kickOk) begin
        faultLed <= 1'b0;
      end
    end
  end

  // R4: each pulse comes with a change of master and a lit fault indicator
  assert_swap_toggles_R4: assert property (@(posedge clk) disable iff (!rst_n)
    failoverPulse |-> activeSel != $past(activeSel));
  assert_pulse_lights_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
    failoverPulse |-> faultLed);
  // R3: the master never changes without a handover pulse
  assert_sel_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !failoverPulse |-> activeSel == $past(activeSel));
  // R6: a counted kick leaves the indicator dark
  assert_kick_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (kickValid && kickId == activeSel) |=> !faultLed);
  // R7: the double-fault flag is sticky
  assert_double_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    doubleFault |=> doubleFault);
endmodule

// File: rtl/cpu_failover_wd.sv
module cpu_failover_wd
  import wdfo_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kickValid,
  input  logic             kickId,
  input  logic [CNT_W-1:0] timeoutCycles,
  output logic             activeSel,
  output logic             faultLed,
  output logic             doubleFault,
  output logic             failoverPulse
);
  wdStrobes_t strobes;
  logic       expireNow;

  wdfo_timer #(.CNT_W(CNT_W)) timer_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .strobes       (strobes),
    .timeoutCycles (timeoutCycles),
    .expireNow     (expireNow)
  );

  wdfo_ctrl ctrl_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .kickValid     (kickValid),
    .kickId        (kickId),
    .expireNow     (expireNow),
    .strobes       (strobes),
    .activeSel     (activeSel),
    .faultLed      (faultLed),
    .doubleFault   (doubleFault),
    .failoverPulse (failoverPulse)
  );
endmodule

// File: tb/cpu_failover_wd_tb_top.sv
`timescale 1ns/1ps
module cpu_failover_wd_tb_top;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             kickValid = 1'b0;
  logic             kickId = 1'b0;
  logic [CNT_W-1:0] timeoutCycles = CNT_W'(5);
  logic             activeSel, faultLed, doubleFault, failoverPulse;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit driverDone = 1'b0;

  typedef struct {
    int    when;
    logic  sel;
    logic  fault;
    logic  dbl;
    logic  pulse;
    string tag;
  } expItem_t;

  expItem_t expQ[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cpu_failover_wd #(.CNT_W(CNT_W)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .kickValid     (kickValid),
    .kickId        (kickId),
    .timeoutCycles (timeoutCycles),
    .activeSel     (activeSel),
    .faultLed      (faultLed),
    .doubleFault   (doubleFault),
    .failoverPulse (failoverPulse)
  );

  task automatic compareNow(input logic s, input logic f, input logic d,
                            input logic p, input string tag);
    checks++;
    if (activeSel !== s || faultLed !== f || doubleFault !== d || failoverPulse !== p) begin
      errors++;
      $display("FAIL %s cyc=%0d: got sel=%0b fault=%0b dbl=%0b pulse=%0b, expected sel=%0b fault=%0b dbl=%0b pulse=%0b",
               tag, cyc, activeSel, faultLed, doubleFault, failoverPulse, s, f, d, p);
    end
  endtask

  // driver side: queue an expectation for a future negedge, in cycle order
  task automatic expectAt(input int when, input logic s, input logic f,
                          input logic d, input logic p, input string tag);
    expItem_t it;
    it.when = when; it.sel = s; it.fault = f; it.dbl = d; it.pulse = p; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic waitUntil(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // monitor: pop and compare items when their cycle arrives
  initial begin
    forever begin
      @(negedge clk);
      while (expQ.size() > 0 && expQ[0].when <= cyc) begin
        expItem_t it;
        it = expQ.pop_front();
        if (it.when < cyc) begin
          checks++; errors++;
          $display("FAIL %s: sample missed at cyc=%0d, expected cyc=%0d", it.tag, cyc, it.when);
        end else begin
          compareNow(it.sel, it.fault, it.dbl, it.pulse, it.tag);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int c0;
    int c1;
    repeat (3) @(negedge clk);
    compareNow(1'b0, 1'b0, 1'b0, 1'b0, "R1 in reset");
    rst_n = 1'b1;
    c0 = cyc;
    compareNow(1'b0, 1'b0, 1'b0, 1'b0, "R1 after release");

    // T=5: restart at c0, handover visible at c0+6
    expectAt(c0+5,  1'b0, 1'b0, 1'b0, 1'b0, "R2 R3 no handover before T+1");
    expectAt(c0+6,  1'b1, 1'b1, 1'b0, 1'b1, "R4 handover to processor 1");
    expectAt(c0+7,  1'b1, 1'b1, 1'b0, 1'b0, "R4 pulse lasts one cycle");
    expectAt(c0+11, 1'b1, 1'b1, 1'b0, 1'b0, "R3 spare kick did not clear fault");
    expectAt(c0+12, 1'b1, 1'b0, 1'b0, 1'b0, "R8 R6 kick at limit rescues and clears");
    expectAt(c0+17, 1'b1, 1'b0, 1'b0, 1'b0, "R2 kick restarted timer");
    expectAt(c0+18, 1'b0, 1'b1, 1'b1, 1'b1, "R7 second expiry returns to processor 0");
    expectAt(c0+19, 1'b0, 1'b1, 1'b1, 1'b0, "R7 fault stays lit");
    expectAt(c0+21, 1'b0, 1'b0, 1'b1, 1'b0, "R7 R6 kick clears fault, flag sticky");
    expectAt(c0+27, 1'b1, 1'b1, 1'b1, 1'b1, "R2 expiry after kick restart");
    expectAt(c0+32, 1'b1, 1'b1, 1'b1, 1'b0, "R5 full interval after handover");
    expectAt(c0+33, 1'b0, 1'b1, 1'b1, 1'b1, "R5 next handover at T+1");

    // R3: standby kick sampled at edge c0+3 must be ignored
    waitUntil(c0+2);
    kickValid = 1'b1; kickId = 1'b1;
    @(negedge clk);
    kickValid = 1'b0;
    // R3: processor 0 (now standby) kicks while fault lit
    waitUntil(c0+8);
    kickValid = 1'b1; kickId = 1'b0;
    @(negedge clk);
    kickValid = 1'b0;
    // R8: processor 1 kicks in the cycle the timer reaches T
    waitUntil(c0+11);
    kickValid = 1'b1; kickId = 1'b1;
    @(negedge clk);
    kickValid = 1'b0;
    // R6: processor 0 kicks after the double fault
    waitUntil(c0+20);
    kickValid = 1'b1; kickId = 1'b0;
    @(negedge clk);
    kickValid = 1'b0;
    waitUntil(c0+34);

    // second reset, shorter timeout
    rst_n = 1'b0;
    timeoutCycles = CNT_W'(2);
    repeat (2) @(negedge clk);
    compareNow(1'b0, 1'b0, 1'b0, 1'b0, "R1 reset clears double fault");
    rst_n = 1'b1;
    c1 = cyc;
    expectAt(c1+2, 1'b0, 1'b0, 1'b0, 1'b0, "R2 T=2 before expiry");
    expectAt(c1+3, 1'b1, 1'b1, 1'b0, 1'b1, "R2 R4 T=2 handover");
    waitUntil(c1+5);
    driverDone = 1'b1;
  end

  initial begin
    wait (driverDone);
    while (expQ.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule